// File: doc/BRIEF.md
# Dual-Channel Frame Buffer Fetch Engine

This block keeps the pixel input FIFOs of a display controller filled from a frame buffer in external memory. It has two fetch channels. Each channel has a base register that software writes and a current pointer inside the block. The first channel serves the only panel of a single-panel display, or the upper half of a split display. The second channel runs only in split (dual-panel) mode and serves the lower half.

A channel asks for data when its FIFO reports at least four free entries. The block then acts as a bus master. It raises a request that carries the burst start address. After one grant it accepts four read beats and passes each beat straight into the FIFO of the channel being served. The frame length comes from the panel geometry and the pixel depth, plus a fixed palette area at the start of the buffer. When a channel's pointer reaches the end of its frame, it reloads from the base register. Each reload sets a sticky flag that tells software it may now write the base address for the next frame.

Software programs the block through a small register port with four word slots: control at 0, base of channel 1 at 1, base of channel 2 at 2 and status at 3. It writes both base registers first and then sets the enable bit.

Top module: `frameFetchDma`

## Requirements
- R1: On a 0-to-1 change of the enable bit (control bit 0), channel 1 copies its base into its pointer. In dual mode (control bit 1 = 1), channel 2 does the same. The first word fetched by each channel then comes from its base address.
- R2: A channel raises a request only while its FIFO free count is 4 or more. With a free count of 3, no request is made. Once raised, a request is held with a stable address until it is granted.
- R3: Each grant is followed by exactly four pushes into the served FIFO. The words come from consecutive addresses, 4 bytes apart, starting at the request address. Each pushed word equals the bus read data.
- R4: The frame ends at start + roundup16(PAL_BYTES + ceil(PPL*LPP*bpp/8)). PPL is control bits [14:5] and LPP is control bits [24:15]. Control bits [4:3] select the pixel depth: 0 gives 4 bits, 1 gives 8 bits, and 2 or 3 give 16 bits. PAL_BYTES defaults to 32. The word after the last word of a frame is fetched from the base address again.
- R5: Every base-to-pointer copy sets status bit 0. Writing 1 to status bit 0 clears it. The irq output equals status bit 0 AND the interrupt mask bit (control bit 2).
- R6: The base registers store only address bits [31:4]. Bits [3:0] always read back as zero.
- R7: When both channels are ready, channel 1 is served first. In single-panel mode, channel 2 never requests or pushes, even when its FIFO has room. At most one FIFO is pushed in any cycle.
- R8: Clearing the enable bit stops new requests. A burst that has already been granted still delivers all four words.
- R9: After reset, no request is raised, irq is low, and the control and status registers read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write slot |
| wrData | input | ADDR_W | Register write data |
| rdAddr | input | 2 | Register read slot |
| rdData | output | ADDR_W | Register read data (combinational) |
| fifoFree1 | input | FREE_W | Free entries in the channel 1 FIFO |
| fifoFree2 | input | FREE_W | Free entries in the channel 2 FIFO |
| busReq | output | 1 | Bus master request |
| busAddr | output | ADDR_W | Burst start address, valid while busReq is high |
| busGrant | input | 1 | Grant for the pending request |
| rdValid | input | 1 | Read beat valid |
| busData | input | DATA_W | Read beat data |
| fifoPush1 | output | 1 | Push strobe into the channel 1 FIFO |
| fifoPush2 | output | 1 | Push strobe into the channel 2 FIFO |
| fifoData | output | DATA_W | Word pushed into the FIFO |
| irq | output | 1 | Interrupt request for a base reload |

## Verification
The hardest case to reach is the wrap at the end of a frame. It needs one exact pixel-depth and geometry combination, and the reload only shows when the following burst starts again at the base. The stimulus table therefore uses very small panels, including an odd pixel count at 4 bits per pixel and the reserved depth code. With these, a whole frame passes in a few bursts, and the word after the frame can be compared with the base. Channel 2 is reached by holding both FIFOs ready to show priority, and then starving channel 1 so that the lower panel gets the bus.

// File: rtl/frameFetchPkg.sv
package frameFetchPkg;
  localparam int BURST_LEN  = 4;
  localparam int WORD_BYTES = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_DATA} fetchState_t;

  typedef struct packed {
    logic incr;   // one word landed: step the served pointer
    logic wrap;   // last word of the frame: reload from base
    logic chSel;  // channel being served (0 = first, 1 = second)
  } fetchStrobe_t;
endpackage

// File: rtl/frameFetchCtrl.sv
module frameFetchCtrl
  import frameFetchPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         fetchEn,
  input  logic         dualMode,
  input  logic         freeOk1,
  input  logic         freeOk2,
  input  logic         busGrant,
  input  logic         rdValid,
  input  logic         wrapHit,
  output logic         busReq,
  output logic         fifoPush1,
  output logic         fifoPush2,
  output fetchStrobe_t strb
);
  localparam int BEAT_W = $clog2(BURST_LEN);

  fetchState_t state, stateNxt;
  logic selReg, selNxt;
  logic [BEAT_W-1:0] beat;
  logic lastBeat, push;

  assign lastBeat = (beat == BEAT_W'(BURST_LEN - 1));
  assign push     = (state == ST_DATA) && rdValid;

  always_comb begin
    stateNxt = state;
    selNxt   = selReg;
    case (state)
      ST_IDLE: begin
        if (fetchEn && freeOk1) begin
          selNxt   = 1'b0;
          stateNxt = ST_REQ;
        end else if (fetchEn && dualMode && freeOk2) begin
          selNxt   = 1'b1;
          stateNxt = ST_REQ;
        end
      end
      ST_REQ: begin
        if (!fetchEn)      stateNxt = ST_IDLE;
        else if (busGrant) stateNxt = ST_DATA;
      end
      ST_DATA: begin
        if (rdValid && lastBeat) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      selReg <= 1'b0;
      beat   <= '0;
    end else begin
      state  <= stateNxt;
      selReg <= selNxt;
      if (state != ST_DATA) beat <= '0;
      else if (rdValid)     beat <= beat + 1'b1;
    end
  end

  assign busReq     = (state == ST_REQ);
  assign fifoPush1  = push && !selReg;
  assign fifoPush2  = push && selReg;
  assign strb.incr  = push;
  assign strb.wrap  = push && lastBeat && wrapHit;
  assign strb.chSel = selReg;
endmodule

// File: rtl/frameFetchPath.sv
module frameFetchPath
  import frameFetchPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PPL_W     = 10,
  parameter int LPP_W     = 10,
  parameter int PAL_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [ADDR_W-1:0] rdData,
  input  fetchStrobe_t      strb,
  output logic [ADDR_W-1:0] curAddr,
  output logic              wrapHit,
  output logic              fetchEn,
  output logic              dualMode,
  output logic              irq
);
  localparam int PPL_LSB = 5;
  localparam int LPP_LSB = PPL_LSB + PPL_W;
  localparam int CTRL_W  = LPP_LSB + LPP_W;
  localparam int PIX_W   = PPL_W + LPP_W;
  localparam int ALIGN_B = BURST_LEN * WORD_BYTES;

  logic             irqMask, enPrev, enRise, statusBit;
  logic [1:0]       bppCode;
  logic [PPL_W-1:0] pplReg;
  logic [LPP_W-1:0] lppReg;
  logic [ADDR_W-1:0] baseReg  [2];
  logic [ADDR_W-1:0] curPtr   [2];
  logic [ADDR_W-1:0] startPtr [2];
  logic [ADDR_W-1:0] endAddr  [2];
  logic [PIX_W-1:0]  pixCount;
  logic [PIX_W+1:0]  pixBytes;
  logic [ADDR_W-1:0] rawBytes, frameBytes, nextPtr;

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchEn  <= 1'b0;
      dualMode <= 1'b0;
      irqMask  <= 1'b0;
      bppCode  <= '0;
      pplReg   <= '0;
      lppReg   <= '0;
      enPrev   <= 1'b0;
    end else begin
      enPrev <= fetchEn;
      if (wrEn && wrAddr == 2'd0) begin
        fetchEn  <= wrData[0];
        dualMode <= wrData[1];
        irqMask  <= wrData[2];
        bppCode  <= wrData[4:3];
        pplReg   <= wrData[PPL_LSB +: PPL_W];
        lppReg   <= wrData[LPP_LSB +: LPP_W];
      end
    end
  end

  assign enRise = fetchEn && !enPrev;

  // frame size shared by both channels
  assign pixCount = PIX_W'(pplReg) * PIX_W'(lppReg);
  always_comb begin
    case (bppCode)
      2'd0:    pixBytes = ({2'b00, pixCount} + 1'b1) >> 1;
      2'd1:    pixBytes = {2'b00, pixCount};
      default: pixBytes = {1'b0, pixCount, 1'b0};
    endcase
  end
  assign rawBytes   = ADDR_W'(pixBytes) + ADDR_W'(PAL_BYTES) + ADDR_W'(ALIGN_B - 1);
  assign frameBytes = rawBytes & ~ADDR_W'(ALIGN_B - 1);

  assign curAddr = curPtr[strb.chSel];
  assign nextPtr = curAddr + ADDR_W'(WORD_BYTES);
  assign wrapHit = (nextPtr == endAddr[strb.chSel]);

  for (genvar c = 0; c < 2; c++) begin : g_chan
    logic served, reloadNow;
    assign served    = (strb.chSel == 1'(c));
    assign reloadNow = (enRise && (c == 0 || dualMode)) ||
                       (!enRise && strb.incr && strb.wrap && served);
    assign endAddr[c] = startPtr[c] + frameBytes;

    // base holds no reset value; low bits never stored
    always_ff @(posedge clk) begin
      if (wrEn && wrAddr == 2'(c + 1))
        baseReg[c] <= {wrData[ADDR_W-1:4], 4'b0000};
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        curPtr[c]   <= '0;
        startPtr[c] <= '0;
      end else if (reloadNow) begin
        curPtr[c]   <= baseReg[c];
        startPtr[c] <= baseReg[c];
      end else if (!enRise && strb.incr && served) begin
        curPtr[c] <= nextPtr;
      end
    end
  end

  // sticky reload flag, write-one-to-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                statusBit <= 1'b0;
    else if (enRise || (strb.incr && strb.wrap)) statusBit <= 1'b1;
    else if (wrEn && wrAddr == 2'd3 && wrData[0]) statusBit <= 1'b0;
  end

  assign irq = statusBit && irqMask;

  always_comb begin
    case (rdAddr)
      2'd0:    rdData = {{(ADDR_W-CTRL_W){1'b0}}, lppReg, pplReg, bppCode,
                         irqMask, dualMode, fetchEn};
      2'd1:    rdData = baseReg[0];
      2'd2:    rdData = baseReg[1];
      default: rdData = {{(ADDR_W-1){1'b0}}, statusBit};
    endcase
  end
endmodule

// File: rtl/frameFetchDma.sv
module frameFetchDma
  import frameFetchPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int FREE_W    = 5,
  parameter int PPL_W     = 10,
  parameter int LPP_W     = 10,
  parameter int PAL_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [ADDR_W-1:0] rdData,
  input  logic [FREE_W-1:0] fifoFree1,
  input  logic [FREE_W-1:0] fifoFree2,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              busGrant,
  input  logic              rdValid,
  input  logic [DATA_W-1:0] busData,
  output logic              fifoPush1,
  output logic              fifoPush2,
  output logic [DATA_W-1:0] fifoData,
  output logic              irq
);
  fetchStrobe_t strb;
  logic fetchEn, dualMode, wrapHit, freeOk1, freeOk2;

  assign freeOk1  = (fifoFree1 >= FREE_W'(BURST_LEN));
  assign freeOk2  = (fifoFree2 >= FREE_W'(BURST_LEN));
  assign fifoData = busData;

  frameFetchCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .fetchEn(fetchEn), .dualMode(dualMode),
    .freeOk1(freeOk1), .freeOk2(freeOk2), .busGrant(busGrant),
    .rdValid(rdValid), .wrapHit(wrapHit), .busReq(busReq),
    .fifoPush1(fifoPush1), .fifoPush2(fifoPush2), .strb(strb)
  );

  frameFetchPath #(
    .ADDR_W(ADDR_W), .PPL_W(PPL_W), .LPP_W(LPP_W), .PAL_BYTES(PAL_BYTES)
  ) i_path (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .strb(strb), .curAddr(busAddr),
    .wrapHit(wrapHit), .fetchEn(fetchEn), .dualMode(dualMode), .irq(irq)
  );
endmodule

// File: rtl/frameFetchDmaChk.sv
module frameFetchDmaChk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busGrant,
  input logic [ADDR_W-1:0] busAddr,
  input logic              fifoPush1,
  input logic              fifoPush2,
  input logic              fetchEn,
  input logic [1:0]        rdAddr,
  input logic [ADDR_W-1:0] rdData
);
  logic [2:0] beatsSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     beatsSeen <= '0;
    else if (busReq && busGrant)   beatsSeen <= '0;
    else if (fifoPush1 || fifoPush2) beatsSeen <= beatsSeen + 1'b1;
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGrant && fetchEn) |=> (busReq && $stable(busAddr)));

  assert_burst_len_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fifoPush1 || fifoPush2) |-> (beatsSeen < 3'd4));

  assert_base_low_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == 2'd1 || rdAddr == 2'd2) |-> (rdData[3:0] == 4'h0));

  assert_single_push_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoPush1 && fifoPush2));

  assert_no_new_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchEn && !busReq) |=> !busReq);
endmodule

bind frameFetchDma frameFetchDmaChk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_frameFetchDma.sv
`timescale 1ns/1ps
module test_frameFetchDma;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [4:0]  fifoFree1 = '0, fifoFree2 = '0;
  logic        busReq, busGrant = 1'b0, rdValid = 1'b0;
  logic [31:0] busAddr, busData = '0, fifoData;
  logic        fifoPush1, fifoPush2, irq;

  always #4 clk = ~clk;  // 125 MHz

  frameFetchDma i_frameFetchDma (.*);

  int nChecks = 0, nFail = 0;
  logic [31:0] cap1 [128];
  logic [31:0] cap2 [128];
  int n1 = 0, n2 = 0, firstCh = 0, reqSeen = 0;

  typedef struct packed {
    logic [1:0]  bpp;
    logic [9:0]  ppl;
    logic [9:0]  lpp;
    logic [31:0] base;
    logic [7:0]  words;
  } vec_t;

  // expected words per frame = roundup16(32 + ceil(ppl*lpp*bpp/8)) / 4
  localparam vec_t VECS [4] = '{
    '{2'd0, 10'd3,  10'd3, 32'h0001_0000, 8'd12},  // 9 px @4b -> 5 B
    '{2'd1, 10'd8,  10'd4, 32'h0002_0040, 8'd16},  // 32 px @8b
    '{2'd2, 10'd10, 10'd3, 32'h0003_0080, 8'd24},  // 30 px @16b
    '{2'd3, 10'd9,  10'd2, 32'h0004_00C0, 8'd20}   // reserved code -> 16b
  };

  function automatic logic [31:0] ctrlWord(input logic en, input logic dual,
      input logic mask, input logic [1:0] bpp, input logic [9:0] ppl,
      input logic [9:0] lpp);
    return {7'b0, lpp, ppl, bpp, mask, dual, en};
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    rdAddr = a; #1; d = rdData;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic waitPush1(input int target);
    for (int g = 0; g < 3000 && n1 < target; g++) @(posedge clk);
  endtask

  task automatic waitPush2(input int target);
    for (int g = 0; g < 3000 && n2 < target; g++) @(posedge clk);
  endtask

  // FIFO capture, sampled away from the active edge
  always @(negedge clk) begin
    if (fifoPush1) begin
      if (n1 == 0 && n2 == 0) firstCh = 1;
      if (n1 < 128) cap1[n1] = fifoData;
      n1++;
    end
    if (fifoPush2) begin
      if (n1 == 0 && n2 == 0) firstCh = 2;
      if (n2 < 128) cap2[n2] = fifoData;
      n2++;
    end
    if (busReq) reqSeen++;
  end

  // memory model: one-cycle grant, then four beats whose data is the address
  initial begin
    logic [31:0] a;
    forever begin
      @(posedge clk); #1;
      if (busReq) begin
        a = busAddr;
        busGrant = 1'b1;
        @(posedge clk); #1;
        busGrant = 1'b0;
        for (int i = 0; i < 4; i++) begin
          rdValid = 1'b1;
          busData = a + 32'(4 * i);
          @(posedge clk); #1;
        end
        rdValid = 1'b0;
      end
    end
  end

  initial begin
    waitCycles(150000);
    nFail++;
    $display("FAIL watchdog R1..: actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    waitCycles(3);
    #1 rstN = 1'b1;
    waitCycles(2); #1;

    // R9 reset state
    check("R9 busReq", {31'b0, busReq}, 32'h0);
    check("R9 irq", {31'b0, irq}, 32'h0);
    regRead(2'd0, r); check("R9 ctrl", r, 32'h0);
    regRead(2'd3, r); check("R9 status", r, 32'h0);

    // R6 low bits of base
    regWrite(2'd1, 32'h1234_567F);
    regRead(2'd1, r); check("R6 base1", r, 32'h1234_5670);
    regWrite(2'd2, 32'hABCD_EF0F);
    regRead(2'd2, r); check("R6 base2", r, 32'hABCD_EF00);

    // table of frame geometries: R1 start, R3 stepping, R4 wrap
    foreach (VECS[v]) begin
      regWrite(2'd0, 32'h0);
      regWrite(2'd1, VECS[v].base);
      n1 = 0; n2 = 0;
      fifoFree1 = 5'd8;
      regWrite(2'd0, ctrlWord(1'b1, 1'b0, 1'b1, VECS[v].bpp, VECS[v].ppl, VECS[v].lpp));
      waitPush1(int'(VECS[v].words) + 4);
      fifoFree1 = 5'd0;
      waitCycles(20);
      check("R1 first word", cap1[0], VECS[v].base);
      check("R3 second word", cap1[1], VECS[v].base + 32'd4);
      check("R4 last of frame", cap1[VECS[v].words - 1],
            VECS[v].base + 32'(4 * (int'(VECS[v].words) - 1)));
      check("R4 wrap to base", cap1[VECS[v].words], VECS[v].base);
      check("R5 irq after reload", {31'b0, irq}, 32'h1);
      regWrite(2'd3, 32'h1);
    end
    regWrite(2'd0, 32'h0);

    // R2 threshold: 3 free entries, no request
    regWrite(2'd1, 32'h0000_1000);
    n1 = 0; reqSeen = 0;
    fifoFree1 = 5'd3;
    regWrite(2'd0, ctrlWord(1'b1, 1'b0, 1'b0, 2'd1, 10'd100, 10'd100));
    waitCycles(15);
    check("R2 no req at 3 free", 32'(reqSeen), 32'h0);
    fifoFree1 = 5'd4;
    waitPush1(4);
    fifoFree1 = 5'd0;
    waitCycles(10);
    check("R2 req at 4 free", 32'(n1), 32'd4);
    check("R3 burst last word", cap1[3], 32'h0000_100C);

    // R5 status with mask off, then on, then write-one-to-clear
    check("R5 irq masked", {31'b0, irq}, 32'h0);
    regRead(2'd3, r); check("R5 status set", r, 32'h1);
    regWrite(2'd0, ctrlWord(1'b1, 1'b0, 1'b1, 2'd1, 10'd100, 10'd100));
    check("R5 irq unmasked", {31'b0, irq}, 32'h1);
    regWrite(2'd3, 32'h1);
    regRead(2'd3, r); check("R5 status cleared", r, 32'h0);
    check("R5 irq cleared", {31'b0, irq}, 32'h0);
    regWrite(2'd0, 32'h0);

    // R8 disable during a granted burst
    regWrite(2'd1, 32'h0000_2000);
    n1 = 0;
    fifoFree1 = 5'd8;
    regWrite(2'd0, ctrlWord(1'b1, 1'b0, 1'b0, 2'd1, 10'd100, 10'd100));
    waitPush1(1);
    regWrite(2'd0, ctrlWord(1'b0, 1'b0, 1'b0, 2'd1, 10'd100, 10'd100));
    waitCycles(30);
    check("R8 burst finished, no more", 32'(n1), 32'd4);
    check("R8 last word", cap1[3], 32'h0000_200C);
    fifoFree1 = 5'd0;

    // R7 dual mode priority and channel 2 start
    regWrite(2'd1, 32'h0000_4000);
    regWrite(2'd2, 32'h0000_8000);
    n1 = 0; n2 = 0; firstCh = 0;
    fifoFree1 = 5'd8; fifoFree2 = 5'd8;
    regWrite(2'd0, ctrlWord(1'b1, 1'b1, 1'b0, 2'd1, 10'd100, 10'd100));
    waitPush1(4);
    fifoFree1 = 5'd0;
    waitPush2(4);
    fifoFree2 = 5'd0;
    waitCycles(20);
    check("R7 channel 1 first", 32'(firstCh), 32'd1);
    check("R1 channel 2 start", cap2[0], 32'h0000_8000);
    check("R3 channel 2 step", cap2[3], 32'h0000_800C);
    regWrite(2'd0, 32'h0);

    // R7 single mode ignores channel 2
    n2 = 0; reqSeen = 0;
    fifoFree2 = 5'd8;
    regWrite(2'd0, ctrlWord(1'b1, 1'b0, 1'b0, 2'd1, 10'd100, 10'd100));
    waitCycles(30);
    check("R7 no ch2 push in single", 32'(n2), 32'h0);
    check("R7 no request in single", 32'(reqSeen), 32'h0);
    regWrite(2'd0, 32'h0);
    fifoFree2 = 5'd0;

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule